// File: doc/BRIEF.md
# Program Memory Fetch Interface

This block sits between a small 8-bit controller core and its program store. The core presents a 16-bit fetch address together with a one-cycle request. The block returns one byte with a one-cycle valid pulse. Depending on the address and on a board-level strap input, the byte comes from a 4 KB on-chip program array or from an external memory device.

External fetches run on a multiplexed bus. One 8-bit port first carries the low address byte, which is marked by a latch-enable pulse so that an external latch can hold it. The same port is then released, and an active-low read strobe enables the memory's output drivers. A second 8-bit port carries the high address byte for the whole cycle. The byte on the shared port is captured on the edge where the strobe returns high.

The on-chip array is a computed stand-in for a mask-programmed store. On-chip fetches leave every external pin untouched.

Top module: `prog_fetch_if`

## Requirements
- R1: After a synchronous reset, `rd_strobe_n` is 1, `addr_latch` is 0, `ad_oe` is 0, `ad_out` and `hi_addr` are 0, and `fetch_valid` is 0.
- R2: A fetch is external when `strap_onchip` is 0, or when the address is above 0FFFh. It is on-chip only when `strap_onchip` is 1 and the address is in 0000h–0FFFh.
- R3: An on-chip fetch accepted at a clock edge raises `fetch_valid` for exactly one cycle, right after that edge. `fetch_data` then equals address[7:0] XOR {4'hA, address[11:8]}.
- R4: On the first cycle after an external fetch is accepted, `addr_latch` is 1 for exactly one cycle. During that cycle `ad_out` holds address[7:0], `ad_oe` is 1 and `rd_strobe_n` is 1.
- R5: In the cycle after `addr_latch` falls, the low address stays driven on the shared port. After that, `ad_oe` is 0 and `rd_strobe_n` is 0 for READ_CYCLES cycles (2 by default).
- R6: From the latch-enable cycle until the strobe ends, `hi_addr` holds address[15:8] and does not change.
- R7: `fetch_data` takes the value of `ad_in` sampled at the clock edge where `rd_strobe_n` returns to 1. `fetch_valid` is high for the cycle after that edge, which is the fifth cycle after acceptance.
- R8: An on-chip fetch leaves `rd_strobe_n` high, `addr_latch` low, and `ad_out`, `ad_oe` and `hi_addr` unchanged.
- R9: While an external fetch is in progress, `fetch_req` is ignored, and the address and strap inputs have no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | One-cycle fetch request |
| fetch_addr | input | 16 | Fetch address |
| strap_onchip | input | 1 | 1: low 4 KB is served on-chip; 0: everything external |
| fetch_data | output | 8 | Fetched byte |
| fetch_valid | output | 1 | One-cycle pulse marking `fetch_data` |
| ad_in | input | 8 | Shared low-address/data port, input side |
| ad_out | output | 8 | Shared port, output side (low address) |
| ad_oe | output | 1 | Output enable of the shared port (0 = high impedance) |
| hi_addr | output | 8 | High address byte port |
| addr_latch | output | 1 | Address latch enable pulse |
| rd_strobe_n | output | 1 | Active-low program read strobe |

## Verification
Some rules hold on every cycle, and the assertions check them continuously:
- the strobe and the latch enable never overlap;
- the shared port is released whenever the strobe is low;
- the high address is steady throughout a strobe;
- a valid pulse from the external path coincides with the strobe's rising edge;
- an on-chip result never coincides with bus activity.

Other behaviour can only be shown by the bench's scenarios, because it depends on an external memory's contents and on the exact cycle of each bus phase:
- the address decode under both strap levels;
- the exact bytes returned from both sources;
- the cycle-by-cycle bus phases;
- requests and address changes being ignored while an external fetch is running.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALE,
    ST_HOLD,
    ST_READ
  } bus_state_t;

  // Computed content of the on-chip program array.
  function automatic logic [7:0] onchip_byte(input logic [11:0] a);
    return a[7:0] ^ {4'hA, a[11:8]};
  endfunction
endpackage

// File: rtl/fetch_decode.sv
module fetch_decode #(
  parameter int ADDR_W    = 16,
  parameter int ONCHIP_AW = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strap_onchip,
  output logic              go_ext
);
  localparam int UPPER_W = ADDR_W - ONCHIP_AW;

  logic above_onchip;

  assign above_onchip = (addr[ADDR_W-1:ONCHIP_AW] != {UPPER_W{1'b0}});
  assign go_ext       = !strap_onchip || above_onchip;
endmodule

// File: rtl/onchip_rom.sv
module onchip_rom #(
  parameter int ONCHIP_AW = 12,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ONCHIP_AW-1:0] addr,
  output logic [DATA_W-1:0]    q,
  output logic                 q_valid
);
  import fetch_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= rd_en;
      if (rd_en) q <= DATA_W'(onchip_byte(12'(addr)));
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int READ_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic              addr_latch,
  output logic              rd_strobe_n,
  output logic              idle,
  output logic [DATA_W-1:0] q,
  output logic              q_valid
);
  import fetch_pkg::*;

  localparam int CNT_W = (READ_CYCLES > 1) ? $clog2(READ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READ_CYCLES - 1);

  bus_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      ad_out      <= '0;
      ad_oe       <= 1'b0;
      hi_addr     <= '0;
      addr_latch  <= 1'b0;
      rd_strobe_n <= 1'b1;
      q           <= '0;
      q_valid     <= 1'b0;
    end else begin
      q_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state      <= ST_ALE;
          ad_out     <= addr[DATA_W-1:0];
          ad_oe      <= 1'b1;
          hi_addr    <= addr[ADDR_W-1:DATA_W];
          addr_latch <= 1'b1;
        end
        ST_ALE: begin
          state      <= ST_HOLD;
          addr_latch <= 1'b0;
        end
        ST_HOLD: begin
          state       <= ST_READ;
          ad_oe       <= 1'b0;
          rd_strobe_n <= 1'b0;
          cnt         <= CNT_LAST;
        end
        ST_READ: begin
          if (cnt == '0) begin
            state       <= ST_IDLE;
            rd_strobe_n <= 1'b1;
            q           <= ad_in;
            q_valid     <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ale_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    addr_latch |-> (rd_strobe_n && ad_oe));

  assert_port_released_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_n |-> !ad_oe);

  assert_hi_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_strobe_n && $past(!rd_strobe_n)) |-> $stable(hi_addr));

  assert_capture_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> (rd_strobe_n && $past(!rd_strobe_n)));

  assert_busy_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(!idle)) |-> ($stable(hi_addr) && $stable(ad_out)));
endmodule

// File: rtl/prog_fetch_if.sv
module prog_fetch_if #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ONCHIP_AW   = 12,
  parameter int READ_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              strap_onchip,
  output logic [DATA_W-1:0] fetch_data,
  output logic              fetch_valid,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic              addr_latch,
  output logic              rd_strobe_n
);
  logic              go_ext, seq_idle, accept;
  logic [DATA_W-1:0] rom_q, ext_q;
  logic              rom_v, ext_v;

  fetch_decode #(.ADDR_W(ADDR_W), .ONCHIP_AW(ONCHIP_AW)) u_dec (
    .addr(fetch_addr), .strap_onchip(strap_onchip), .go_ext(go_ext)
  );

  assign accept = fetch_req && seq_idle;

  onchip_rom #(.ONCHIP_AW(ONCHIP_AW), .DATA_W(DATA_W)) u_rom (
    .clk(clk), .rst(rst), .rd_en(accept && !go_ext),
    .addr(fetch_addr[ONCHIP_AW-1:0]), .q(rom_q), .q_valid(rom_v)
  );

  ext_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_CYCLES(READ_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(accept && go_ext), .addr(fetch_addr),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr),
    .addr_latch(addr_latch), .rd_strobe_n(rd_strobe_n), .idle(seq_idle),
    .q(ext_q), .q_valid(ext_v)
  );

  assign fetch_data  = rom_v ? rom_q : ext_q;
  assign fetch_valid = rom_v || ext_v;

  assert_onchip_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    rom_v |-> (rd_strobe_n && !addr_latch && $stable(hi_addr) && $stable(ad_oe)));

  assert_single_source_R3: assert property (@(posedge clk) disable iff (rst)
    !(rom_v && ext_v));
endmodule

// File: tb/prog_fetch_if_test.sv
module prog_fetch_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {strap_onchip, address}
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b1, 16'h0000}, {1'b1, 16'h0FFF}, {1'b1, 16'h1000}, {1'b0, 16'h0000},
    {1'b0, 16'h0FFF}, {1'b1, 16'hFFFF}, {1'b1, 16'h0ABC}, {1'b0, 16'h8123}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        strap_onchip = 1'b1;
  logic [7:0]  fetch_data, ad_in, ad_out, hi_addr, lat_lo;
  logic        fetch_valid, ad_oe, addr_latch, rd_strobe_n;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_fetch_if uut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .strap_onchip(strap_onchip), .fetch_data(fetch_data), .fetch_valid(fetch_valid),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr),
    .addr_latch(addr_latch), .rd_strobe_n(rd_strobe_n)
  );

  function automatic logic [7:0] ext_mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h96;
  endfunction

  function automatic logic [7:0] rom_val(input logic [15:0] a);
    return a[7:0] ^ {4'hA, a[11:8]};
  endfunction

  // External latch and memory model: drives data only while strobe is low.
  always_ff @(posedge clk) if (addr_latch) lat_lo <= ad_out;
  assign ad_in = !rd_strobe_n ? ext_mem({hi_addr, lat_lo}) : 8'h3C;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_fetch(input logic strap, input logic [15:0] a, input logic mess);
    logic ext = !strap || (a > 16'h0FFF);
    logic [7:0] p_out = ad_out;
    logic [7:0] p_hi = hi_addr;
    logic p_oe = ad_oe;
    @(negedge clk);
    strap_onchip = strap; fetch_addr = a; fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = mess;
    if (mess) begin fetch_addr = ~a; strap_onchip = ~strap; end
    if (!ext) begin
      check("R3 valid", fetch_valid, 1);
      check("R3 data", fetch_data, rom_val(a));
      check("R8 strobe/ale", {rd_strobe_n, addr_latch}, 2'b10);
      check("R8 port", {p_oe, p_out, p_hi}, {ad_oe, ad_out, hi_addr});
    end else begin
      check("R4 ale phase", {addr_latch, ad_oe, rd_strobe_n, ad_out}, {3'b111, a[7:0]});
      check("R6 hi", hi_addr, a[15:8]);
      check("R2 not onchip", fetch_valid, 0);
      @(negedge clk);
      check("R5 hold", {addr_latch, ad_oe, rd_strobe_n, ad_out}, {3'b011, a[7:0]});
      @(negedge clk);
      check("R5 strobe1", {ad_oe, rd_strobe_n}, 2'b00);
      check("R6 hi strobe", hi_addr, a[15:8]);
      @(negedge clk);
      check("R5 strobe2", {ad_oe, rd_strobe_n, fetch_valid}, 3'b000);
      fetch_req = 1'b0;
      @(negedge clk);
      check("R7 valid", {fetch_valid, rd_strobe_n}, 2'b11);
      check("R7 data", fetch_data, ext_mem(a));
    end
    fetch_req = 1'b0;
    @(negedge clk);
    check("R9 no extra cycle", {fetch_valid, addr_latch}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset outputs", {rd_strobe_n, addr_latch, ad_oe, fetch_valid}, 4'b1000);
    check("R1 reset ports", {ad_out, hi_addr}, 16'h0000);
    for (int i = 0; i < NVEC; i++) run_fetch(VECS[i][16], VECS[i][15:0], 1'b0);
    // R9: request held with changed address/strap during an external cycle
    run_fetch(1'b1, 16'h5A33, 1'b1);
    // R8: on-chip fetch right after an external one keeps port state
    run_fetch(1'b1, 16'h0123, 1'b0);
    // R2: boundary addresses under strap low and high
    run_fetch(1'b0, 16'h0800, 1'b0);
    run_fetch(1'b1, 16'h1001, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule